// File: doc/BRIEF.md
# ASCII Hex Record Memory Loader

This block turns a stream of ASCII text into byte writes for an on-chip memory. Characters arrive one per clock with a valid qualifier. The text is a series of lines, and each line is one load record. A record opens with a start address of four hex digits, most significant digit first, followed by one space. Next comes a byte count in hex, ended by a space. Then come that many data bytes. Each byte is two hex digits, and every byte is followed by exactly one space.

Each complete byte produces a one-cycle write strobe with its address and data. The address starts at the record address and steps by one after every byte. Once the last counted byte is written, the rest of the line is a free comment and causes no writes. A malformed line raises a sticky error flag. The parser then drops the rest of that line and starts over on the next one. A typical use is preloading a program or table memory from a character channel during bring-up.

Top module: `hexrec_loader`

## Requirements
- R1: After reset, `wr_en`, `rec_done` and `err` are low, and the parser waits for the first address digit of a record.
- R2: A record's first write goes to the address formed by its first four hex digits, the first digit being the most significant nibble.
- R3: Each data byte, taken as two hex digits followed by a space (0x20), produces exactly one `wr_en` pulse in the cycle after that space is accepted. Byte k of a record (counting from 0) is written to start address + k.
- R4: The count field is one or more hex digits ended by a space, and its value sets the number of bytes. Digits decode over the ASCII range 0x30 to 0x46: '0'..'9' give 0..9 and 'A'..'F' give 10..15.
- R5: Any character that is not a hex digit where a digit is expected sets `err`. This includes the seven codes 0x3A ':' through 0x40 '@' and lower-case letters. The rest of that line then produces no writes, and the following line is parsed as a new record.
- R6: After the space that follows the last counted byte, every character up to line feed (0x0A) is ignored, even if it looks like hex bytes.
- R7: A count of zero produces no writes, no `rec_done`, and no error.
- R8: A line feed that arrives before all counted bytes have been written sets `err`. Bytes completed before it are still written.
- R9: `rec_done` pulses for one cycle, in the same cycle as the write of the record's last byte.
- R10: Carriage return (0x0D) is ignored anywhere it appears. Cycles with `in_valid` low do not advance the parser.
- R11: Once set, `err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_char` holds a character this cycle |
| in_char | input | 8 | ASCII character |
| wr_en | output | 1 | One-cycle memory write strobe |
| wr_addr | output | 4*ADDR_DIGITS (16) | Write address |
| wr_data | output | 8 | Write data byte |
| rec_done | output | 1 | Pulse on the last byte write of a record |
| err | output | 1 | Sticky parse error flag |

## Verification
The bench sends a 16-byte record whose count has two digits and whose data uses every hex digit. A decoder that mishandles the gap between '9' and 'A' writes wrong data, and a count that keeps only one digit stops early. Comments made of valid-looking bytes follow the last byte; a parser that does not skip them writes extra bytes. The bench also sends a ':' in the address field, an '@' inside a data byte, and a line feed that cuts a record short. A design that lacks error handling either writes garbage or never recovers on the next line. Carriage returns and idle gaps are placed in the middle of fields, so a parser that shifts in stray characters ends up with a wrong address.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

  typedef enum logic [2:0] {
    ST_ADDR,
    ST_SP1,
    ST_COUNT,
    ST_DATA_HI,
    ST_DATA_LO,
    ST_DATA_SP,
    ST_SKIP_EOL
  } parse_state_t;

  localparam logic [7:0] CH_SPACE = 8'h20;
  localparam logic [7:0] CH_LF    = 8'h0A;
  localparam logic [7:0] CH_CR    = 8'h0D;

  // decode window for hex digits: '0' .. 'F'
  localparam int unsigned HEX_BASE = 32'h30;
  localparam int unsigned HEX_SPAN = 23;

endpackage

// File: rtl/hexrec_nibble_lut.sv
module hexrec_nibble_lut
  import hexrec_pkg::*;
(
  input  logic [7:0] ch,
  output logic       is_hex,
  output logic [3:0] nib
);

  localparam int IDX_W = $clog2(HEX_SPAN);

  logic [HEX_SPAN-1:0] ok_tbl;
  logic [3:0]          val_tbl [HEX_SPAN];

  // table over the contiguous window; punctuation slots are marked invalid
  for (genvar i = 0; i < HEX_SPAN; i++) begin : g_lut
    localparam bit IS_DIG = (i < 10);
    localparam bit IS_LET = (i >= 17);
    assign ok_tbl[i]  = IS_DIG || IS_LET;
    assign val_tbl[i] = IS_DIG ? 4'(i) : (IS_LET ? 4'(i - 7) : 4'd0);
  end

  logic [7:0]       off;
  logic             in_win;
  logic [IDX_W-1:0] idx;

  always_comb begin
    off    = ch - 8'(HEX_BASE);
    in_win = (ch >= 8'(HEX_BASE)) && (off < 8'(HEX_SPAN));
    idx    = off[IDX_W-1:0];
    is_hex = in_win && ok_tbl[idx];
    nib    = in_win ? val_tbl[idx] : 4'd0;
  end

endmodule

// File: rtl/hexrec_parser.sv
module hexrec_parser
  import hexrec_pkg::*;
#(
  parameter int ADDR_DIGITS = 4,
  parameter int CNT_W       = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [7:0]               in_char,
  input  logic                     is_hex,
  input  logic [3:0]               nib,
  output logic                     wr_en,
  output logic [4*ADDR_DIGITS-1:0] wr_addr,
  output logic [7:0]               wr_data,
  output logic                     rec_done,
  output logic                     err
);

  localparam int ADDR_W = 4 * ADDR_DIGITS;
  localparam int DIG_W  = $clog2(ADDR_DIGITS + 1);

  parse_state_t      state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DIG_W-1:0]  digs_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              cnt_seen_q;
  logic [3:0]        hi_q;
  logic [7:0]        byte_q;

  logic take, is_sp, is_lf;
  assign take  = in_valid && (in_char != CH_CR);
  assign is_sp = (in_char == CH_SPACE);
  assign is_lf = (in_char == CH_LF);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_ADDR;
      addr_q     <= '0;
      digs_q     <= '0;
      cnt_q      <= '0;
      cnt_seen_q <= 1'b0;
      hi_q       <= '0;
      byte_q     <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      rec_done   <= 1'b0;
      err        <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      rec_done <= 1'b0;
      if (take) begin
        // line feed inside a record: flag it and restart on the new line
        if (is_lf && state_q != ST_SKIP_EOL) begin
          if (state_q != ST_ADDR || digs_q != '0) err <= 1'b1;
          state_q <= ST_ADDR;
          digs_q  <= '0;
        end else begin
          unique case (state_q)
            ST_ADDR: begin
              if (is_hex) begin
                addr_q <= (addr_q << 4) | ADDR_W'(nib);
                if (digs_q == DIG_W'(ADDR_DIGITS - 1)) begin
                  digs_q  <= '0;
                  state_q <= ST_SP1;
                end else begin
                  digs_q <= digs_q + 1'b1;
                end
              end else begin
                err     <= 1'b1;
                digs_q  <= '0;
                state_q <= ST_SKIP_EOL;
              end
            end
            ST_SP1: begin
              if (is_sp) begin
                cnt_q      <= '0;
                cnt_seen_q <= 1'b0;
                state_q    <= ST_COUNT;
              end else begin
                err     <= 1'b1;
                state_q <= ST_SKIP_EOL;
              end
            end
            ST_COUNT: begin
              if (is_hex) begin
                cnt_q      <= (cnt_q << 4) | CNT_W'(nib);
                cnt_seen_q <= 1'b1;
              end else if (is_sp && cnt_seen_q) begin
                state_q <= (cnt_q == '0) ? ST_SKIP_EOL : ST_DATA_HI;
              end else begin
                err     <= 1'b1;
                state_q <= ST_SKIP_EOL;
              end
            end
            ST_DATA_HI: begin
              if (is_hex) begin
                hi_q    <= nib;
                state_q <= ST_DATA_LO;
              end else begin
                err     <= 1'b1;
                state_q <= ST_SKIP_EOL;
              end
            end
            ST_DATA_LO: begin
              if (is_hex) begin
                byte_q  <= {hi_q, nib};
                state_q <= ST_DATA_SP;
              end else begin
                err     <= 1'b1;
                state_q <= ST_SKIP_EOL;
              end
            end
            ST_DATA_SP: begin
              if (is_sp) begin
                wr_en   <= 1'b1;
                wr_addr <= addr_q;
                wr_data <= byte_q;
                addr_q  <= addr_q + 1'b1;
                cnt_q   <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                  rec_done <= 1'b1;
                  state_q  <= ST_SKIP_EOL;
                end else begin
                  state_q <= ST_DATA_HI;
                end
              end else begin
                err     <= 1'b1;
                state_q <= ST_SKIP_EOL;
              end
            end
            ST_SKIP_EOL: begin
              if (is_lf) begin
                state_q <= ST_ADDR;
                digs_q  <= '0;
              end
            end
            default: state_q <= ST_ADDR;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader #(
  parameter int ADDR_DIGITS = 4,
  parameter int CNT_W       = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [7:0]               in_char,
  output logic                     wr_en,
  output logic [4*ADDR_DIGITS-1:0] wr_addr,
  output logic [7:0]               wr_data,
  output logic                     rec_done,
  output logic                     err
);

  logic       is_hex;
  logic [3:0] nib;

  hexrec_nibble_lut u_lut (
    .ch     (in_char),
    .is_hex (is_hex),
    .nib    (nib)
  );

  hexrec_parser #(
    .ADDR_DIGITS (ADDR_DIGITS),
    .CNT_W       (CNT_W)
  ) u_parser (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_char  (in_char),
    .is_hex   (is_hex),
    .nib      (nib),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rec_done (rec_done),
    .err      (err)
  );

endmodule

// File: rtl/hexrec_loader_chk.sv
module hexrec_loader_chk #(
  parameter int ADDR_DIGITS = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic [7:0]               in_char,
  input logic                     wr_en,
  input logic [4*ADDR_DIGITS-1:0] wr_addr,
  input logic [7:0]               wr_data,
  input logic                     rec_done,
  input logic                     err
);

  localparam int ADDR_W = 4 * ADDR_DIGITS;

  logic              in_rec;
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_rec    <= 1'b0;
      last_addr <= '0;
    end else begin
      if (wr_en) last_addr <= wr_addr;
      if (in_valid && in_char == 8'h0A) in_rec <= 1'b0;
      else if (rec_done)                in_rec <= 1'b0;
      else if (wr_en)                   in_rec <= 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!wr_en && !rec_done && !err)); // R1

  AST_WR_AFTER_SPACE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(in_valid) && $past(in_char) == 8'h20)); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && in_rec) |-> (wr_addr == last_addr + 1'b1)); // R3

  AST_DONE_WITH_WRITE: assert property (@(posedge clk) disable iff (rst)
    rec_done |-> wr_en); // R9

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !wr_en); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R11

endmodule

bind hexrec_loader hexrec_loader_chk #(.ADDR_DIGITS(ADDR_DIGITS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_char  (in_char),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rec_done (rec_done),
  .err      (err)
);

// File: tb/hexrec_loader_tb.sv
`timescale 1ns/1ps
module hexrec_loader_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_char = 8'h00;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic        rec_done;
  logic        err;

  always #2 clk = ~clk;

  hexrec_loader u_dut (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_char  (in_char),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rec_done (rec_done),
    .err      (err)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // write log captured away from the active edge
  logic [15:0] log_addr [256];
  logic [7:0]  log_data [256];
  int wn = 0;
  int dn = 0;
  int done_alone = 0;
  int cyc = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (wr_en && wn < 256) begin
        log_addr[wn] <= wr_addr;
        log_data[wn] <= wr_data;
      end
      if (wr_en) wn <= wn + 1;
      if (rec_done) dn <= dn + 1;
      if (rec_done && !wr_en) done_alone <= done_alone + 1;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic put(logic [7:0] c);
    @(negedge clk);
    in_valid = 1'b1;
    in_char  = c;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_char  = 8'h31; // a digit, must be ignored while not valid
    end
  endtask

  task automatic send(string s);
    for (int i = 0; i < s.len(); i++) put(s[i]);
    idle(3);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    idle(2);
    rst = 1'b0;
    idle(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "wr_en", int'(wr_en), 0);
    chk("R1", "rec_done", int'(rec_done), 0);
    chk("R1", "err", int'(err), 0);
  endtask

  task automatic t_basic();
    logic [7:0] exp_b [7] = '{8'hAE, 8'h03, 8'hB6, 8'h91, 8'hC7, 8'h00, 8'h0C};
    int b0 = wn;
    int d0 = dn;
    send("12AC 7 AE 03 B6 91 C7 00 0C trailing 11 22 \n");
    chk("R3", "write count", wn - b0, 7);
    for (int i = 0; i < 7; i++) begin
      chk(i == 0 ? "R2" : "R3", "addr", int'(log_addr[b0+i]), 16'h12AC + i);
      chk("R4", "data", int'(log_data[b0+i]), int'(exp_b[i]));
    end
    chk("R9", "done pulses", dn - d0, 1);
    chk("R6", "err after comment", int'(err), 0);
  endtask

  task automatic t_all_digits();
    logic [7:0] exp_b [16] = '{8'h01, 8'h23, 8'h45, 8'h67, 8'h89, 8'hAB, 8'hCD, 8'hEF,
                               8'hFE, 8'hDC, 8'hBA, 8'h98, 8'h76, 8'h54, 8'h32, 8'h10};
    int b0 = wn;
    send("0000 10 01 23 45 67 89 AB CD EF FE DC BA 98 76 54 32 10 \n");
    chk("R4", "two-digit count", wn - b0, 16);
    for (int i = 0; i < 16; i++) begin
      chk("R4", "data", int'(log_data[b0+i]), int'(exp_b[i]));
      chk("R3", "addr", int'(log_addr[b0+i]), i);
    end
  endtask

  task automatic t_cr_idle();
    int b0 = wn;
    put("0"); put("0"); put(8'h0D); idle(2); put("5"); put("B");
    put(" "); put("2"); put(" "); put(8'h0D); put("0"); put("1"); put(" ");
    idle(1); put("F"); put("C"); put(" "); put(8'h0D); put(8'h0A);
    idle(3);
    chk("R10", "write count", wn - b0, 2);
    chk("R10", "addr0", int'(log_addr[b0]), 16'h005B);
    chk("R10", "data0", int'(log_data[b0]), 8'h01);
    chk("R10", "addr1", int'(log_addr[b0+1]), 16'h005C);
    chk("R10", "data1", int'(log_data[b0+1]), 8'hFC);
    chk("R10", "err", int'(err), 0);
  endtask

  task automatic t_zero_count();
    int b0 = wn;
    int d0 = dn;
    send("ABCD 0 55 66 \n");
    chk("R7", "writes", wn - b0, 0);
    chk("R7", "done", dn - d0, 0);
    chk("R7", "err", int'(err), 0);
  endtask

  task automatic t_comment_bytes();
    int b0 = wn;
    send("2000 1 5A 6B 7C \n");
    chk("R6", "writes", wn - b0, 1);
    chk("R6", "data", int'(log_data[b0]), 8'h5A);
  endtask

  task automatic t_invalid();
    int b0;
    do_reset();
    b0 = wn;
    send("30:0 1 11 \n");
    chk("R5", "err on colon", int'(err), 1);
    chk("R5", "no writes", wn - b0, 0);
    send("4000 1 22 \n");
    chk("R5", "recovery writes", wn - b0, 1);
    chk("R5", "recovery addr", int'(log_addr[b0]), 16'h4000);
    chk("R5", "recovery data", int'(log_data[b0]), 8'h22);
    chk("R11", "err sticky", int'(err), 1);
    do_reset();
    b0 = wn;
    send("5000 2 1@ 33 \n");
    chk("R5", "err on at-sign", int'(err), 1);
    chk("R5", "no writes after at-sign", wn - b0, 0);
    do_reset();
    b0 = wn;
    send("5100 1 ab \n");
    chk("R5", "err on lower case", int'(err), 1);
    chk("R5", "no writes lower case", wn - b0, 0);
  endtask

  task automatic t_short();
    int b0;
    int d0;
    do_reset();
    b0 = wn;
    d0 = dn;
    send("6000 3 01 02\n");
    chk("R8", "writes before lf", wn - b0, 1);
    chk("R8", "data", int'(log_data[b0]), 8'h01);
    chk("R8", "err", int'(err), 1);
    chk("R8", "no done", dn - d0, 0);
    send("7000 1 99 \n");
    chk("R8", "next line writes", wn - b0, 2);
    chk("R8", "next line addr", int'(log_addr[b0+1]), 16'h7000);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_basic();
    t_all_digits();
    t_cr_idle();
    t_zero_count();
    t_comment_bytes();
    chk("R9", "done without write", done_alone, 0);
    t_invalid();
    t_short();
    chk("R9", "done without write", done_alone, 0);
    finish_run();
  end

  initial begin
    wait (cyc > 100000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
    finish_run();
  end

endmodule